// File: doc/BRIEF.md
# Selectable-Period Idle Interval Timer

This block is a free-running interval timer that advances once per instruction cycle. A 16-bit up-counter runs all the time. The block sets a sticky pending flag each time the counter's low bits that cover the chosen window all wrap to zero together. A small select field picks the window, from 4,096 up to 65,536 cycles, in powers of two. Software clears the flag. An interrupt request is the flag gated by an enable input.

Changing the select field does not restart the counter. Right after a switch to a shorter window, the flag can therefore rise before a full window has passed since the switch. Software is expected to mask the interrupt and clear the flag around such a change. The block keeps this behaviour on purpose and does not hide it.

Top module: `idle_tmr`

## Requirements
- R1: Select codes 0, 1, 2 and 3 (field bits [2:0] of the control word) give windows of 4,096, 8,192, 16,384 and 32,768 cycles. The flag sets on the enabled cycle in which counter bits [log2(window)-1:0] wrap from all ones to zero.
- R2: Any select code with bit 2 set gives a 65,536-cycle window. Bits 1:0 then have no effect on the window.
- R3: While the synchronous active-low reset is asserted, the control word, the counter and the flag all clear. After reset the first flag rises after exactly 4,096 enabled cycles.
- R4: Writing a new select code leaves the counter running. A switch to a shorter window can therefore set the flag in fewer enabled cycles than the new window length.
- R5: The flag stays set until a clear strobe. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R6: The interrupt request equals the flag ANDed with the interrupt enable input.
- R7: The counter advances only in cycles where the cycle enable is high. Idle cycles neither move it nor set the flag.
- R8: The control readback carries the select code in bits [2:0] and zero in every higher bit. A write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_en | input | 1 | One pulse per instruction cycle; the counter advances when high |
| ctrl_wr | input | 1 | Write strobe for the select field |
| ctrl_wdata | input | 3 | New select code |
| ctrl_rdata | output | 8 | Control readback: select in [2:0], zeros above |
| irq_en | input | 1 | Interrupt enable |
| pend_clr | input | 1 | Software clear of the pending flag |
| pend | output | 1 | Sticky pending flag |
| irq | output | 1 | Interrupt request (pend AND irq_en) |

## Verification
Each select code runs one continuous counter through stretches placed so that the real window and each wrong neighbouring window give different flag outcomes. For example, the bench stops at a multiple of 4,096 that is not a multiple of 8,192, which separates code 1 from code 0. The top-bit codes 5 and 7 run over counter ranges where a decoder that used only bits 1:0 would fire but the true 65,536-cycle window does not. A switch to the shortest window part-way through a window shows that the flag can come early. Idle stretches, a clear that coincides with a wrap, toggling of the interrupt enable and a mid-run reset separate the gating, priority and reset behaviour.

// File: rtl/idle_tmr_pkg.sv
// Shared sizing for the idle interval timer.
// Assumes the smallest window is a power of two no wider than the counter.
package idle_tmr_pkg;
    localparam int CNT_W   = 16;   // free-running counter width
    localparam int MIN_W   = 12;   // log2 of the shortest window
    localparam int SEL_W   = 3;    // select field width
    localparam int CTRL_W  = 8;    // readback word width
    localparam int NUM_WIN = CNT_W - MIN_W + 1;
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
endpackage

// File: rtl/idle_tmr_ctrl.sv
// Control register: holds the select code and drives the readback word.
// Assumes one write strobe; reserved bits are not stored and read as zero.
module idle_tmr_ctrl
    import idle_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  wdata,
    output logic [SEL_W-1:0]  sel,
    output logic [CTRL_W-1:0] rdata
);
    logic [SEL_W-1:0] sel_q;

    // Purpose: capture a new select code on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  sel_q <= '0;
        else if (wr) sel_q <= wdata;
    end

    // Purpose: pad the stored code with zeros to the readback width.
    always_comb begin
        rdata            = '0;
        rdata[SEL_W-1:0] = sel_q;
    end

    assign sel = sel_q;

    // R8: a write is visible at the next edge
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> sel == $past(wdata));
    // R8: without a write the code holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(sel));
endmodule

// File: rtl/idle_tmr_decode.sv
// Maps the select code to a window index (0 = shortest).
// Assumes the top select bit forces the longest window; lower codes past
// the last window clamp to it.
module idle_tmr_decode
    import idle_tmr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] idx
);
    // Purpose: pick the window index, top bit overriding the low bits.
    always_comb begin
        if (sel[SEL_W-1])
            idx = IDX_W'(NUM_WIN - 1);
        else if (int'(sel[SEL_W-2:0]) >= NUM_WIN - 1)
            idx = IDX_W'(NUM_WIN - 1);
        else
            idx = IDX_W'(sel[SEL_W-2:0]);
    end
endmodule

// File: rtl/idle_tmr_cnt.sv
// Free-running up-counter with one wrap detector per selectable window.
// Assumes cyc_en is a single-cycle enable; the counter is never restarted
// by a change of window.
module idle_tmr_cnt
    import idle_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic [IDX_W-1:0]  idx,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_WIN-1:0] roll;
    logic [CNT_W-1:0]   win_mask;

    // Purpose: advance once per enabled cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cyc_en) cnt_q <= cnt_q + 1'b1;
    end

    // One detector per window: low bits all ones means the next step wraps.
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_roll
        assign roll[k] = &cnt_q[MIN_W+k-1:0];
    end

    // Purpose: report a wrap of the selected window on an enabled cycle.
    always_comb begin
        wrap = cyc_en && roll[idx];
    end

    // Purpose: mask of the selected window's bits, used by the checks.
    always_comb begin
        win_mask = CNT_W'((33'd1 << (MIN_W + int'(idx))) - 33'd1);
    end

    assign count = cnt_q;

    // R7: idle cycles leave the counter untouched
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(count));
    // R1: after a wrap the selected low bits read zero
    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count & $past(win_mask)) == '0);
endmodule

// File: rtl/idle_tmr_pend.sv
// Sticky pending flag and gated interrupt request.
// Assumes hardware only sets the flag; software clears it, and a same-cycle
// set wins so no window event is lost.
module idle_tmr_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic pend,
    output logic irq
);
    logic pend_q;

    // Purpose: set on a wrap, clear on request, set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign pend = pend_q;
    assign irq  = pend_q & irq_en;

    // R5: a wrap always leaves the flag set, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pend);
    // R5: no clear, no drop
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);
    // R6: a request never appears with the enable low
    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: rtl/idle_tmr.sv
// Top of the idle interval timer: control register, window decode,
// counter and pending flag. Assumes one cyc_en pulse per instruction cycle.
module idle_tmr
    import idle_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              ctrl_wr,
    input  logic [SEL_W-1:0]  ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              irq_en,
    input  logic              pend_clr,
    output logic              pend,
    output logic              irq
);
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] count;
    logic             wrap;

    idle_tmr_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (ctrl_wdata),
        .sel   (sel),
        .rdata (ctrl_rdata)
    );

    idle_tmr_decode u_dec (
        .sel (sel),
        .idx (idx)
    );

    idle_tmr_cnt u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en),
        .idx    (idx),
        .count  (count),
        .wrap   (wrap)
    );

    idle_tmr_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (wrap),
        .clr    (pend_clr),
        .irq_en (irq_en),
        .pend   (pend),
        .irq    (irq)
    );

    // R2: with the top select bit set, a wrap is a full counter wrap
    a_r2_long_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && sel[SEL_W-1]) |=> count == '0);
    // R3: reset returns the readback and flag to zero
    a_r3_reset_state: assert property (@(posedge clk)
        !rst_n |=> (ctrl_rdata == '0 && !pend));
endmodule

// File: tb/idle_tmr_tb_top.sv
module idle_tmr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [2:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       irq_en = 1'b0;
    logic       pend_clr = 1'b0;
    logic       pend;
    logic       irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    idle_tmr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_en     (cyc_en),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .irq_en     (irq_en),
        .pend_clr   (pend_clr),
        .pend       (pend),
        .irq        (irq)
    );

    // Vector: code to write, enabled cycles to run, expected flag, clear after.
    typedef struct packed {
        logic [2:0]  code;
        logic [31:0] run;
        logic        exp_pend;
        logic        clr;
    } vec_t;

    // Counter value after each row is noted; windows chosen so a wrong
    // window length gives the opposite flag outcome.
    localparam vec_t VECS [15] = '{
        '{3'd0, 32'd4095,  1'b0, 1'b0},  // 4095      R1
        '{3'd0, 32'd1,     1'b1, 1'b1},  // 4096      R1
        '{3'd1, 32'd4096,  1'b1, 1'b1},  // 8192      R1
        '{3'd1, 32'd4096,  1'b0, 1'b0},  // 12288     R1 (4096 would fire)
        '{3'd1, 32'd4096,  1'b1, 1'b1},  // 16384     R1
        '{3'd2, 32'd8192,  1'b0, 1'b0},  // 24576     R1 (8192 would fire)
        '{3'd2, 32'd8192,  1'b1, 1'b1},  // 32768     R1
        '{3'd3, 32'd16384, 1'b0, 1'b0},  // 49152     R1 (16384 would fire)
        '{3'd3, 32'd16384, 1'b1, 1'b1},  // 0 (wrap)  R1
        '{3'd4, 32'd32768, 1'b0, 1'b0},  // 32768     R2 (32768 would fire)
        '{3'd4, 32'd32768, 1'b1, 1'b1},  // 0         R2
        '{3'd5, 32'd8192,  1'b0, 1'b0},  // 8192      R2 (low bits 01 would fire)
        '{3'd7, 32'd24676, 1'b0, 1'b0},  // 32868     R2 (low bits 11 would fire)
        '{3'd0, 32'd3995,  1'b0, 1'b0},  // 36863     R4
        '{3'd0, 32'd1,     1'b1, 1'b0}   // 36864     R4 early flag
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic write_sel(input logic [2:0] code);
        ctrl_wr    = 1'b1;
        ctrl_wdata = code;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic run(input int n);
        cyc_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        cyc_en = 1'b0;
    endtask

    task automatic clear_pend();
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        chk("R3", "rdata after reset", 32'(ctrl_rdata), 32'h00);
        chk("R3", "pend after reset", 32'(pend), 32'd0);
        chk("R6", "irq after reset", 32'(irq), 32'd0);

        // R8: reserved bits read zero, write lands next edge
        write_sel(3'b111);
        chk("R8", "rdata after write 7", 32'(ctrl_rdata), 32'h07);

        // Vector walk over one continuous counter
        for (int v = 0; v < 15; v++) begin
            string tag;
            tag = (v >= 13) ? "R4" : (VECS[v].code[2] ? "R2" : "R1");
            write_sel(VECS[v].code);
            run(int'(VECS[v].run));
            chk(tag, $sformatf("pend vec %0d", v), 32'(pend), 32'(VECS[v].exp_pend));
            if (VECS[v].clr) clear_pend();
        end

        // R6: interrupt gating with flag set
        irq_en = 1'b0;
        #1;
        chk("R6", "irq with enable low", 32'(irq), 32'd0);
        irq_en = 1'b1;
        #1;
        chk("R6", "irq with enable high", 32'(irq), 32'd1);

        // R5: no hardware clear over idle cycles
        repeat (20) @(negedge clk);
        chk("R5", "pend held without clear", 32'(pend), 32'd1);
        clear_pend();
        chk("R5", "pend after clear", 32'(pend), 32'd0);
        chk("R6", "irq after clear", 32'(irq), 32'd0);
        irq_en = 1'b0;

        // R7: counter at 36864, window 4096; stop one short of the wrap
        run(4095);
        chk("R7", "pend one short", 32'(pend), 32'd0);
        repeat (50) @(negedge clk);
        chk("R7", "pend after idle stretch", 32'(pend), 32'd0);

        // R5: wrap and clear together leave the flag set
        pend_clr = 1'b1;
        run(1);
        pend_clr = 1'b0;
        chk("R5", "set beats clear", 32'(pend), 32'd1);

        // R3: mid-run reset with a long window selected
        write_sel(3'd3);
        run(100);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R3", "rdata after second reset", 32'(ctrl_rdata), 32'h00);
        chk("R3", "pend after second reset", 32'(pend), 32'd0);
        run(4095);
        chk("R3", "pend at 4095 after reset", 32'(pend), 32'd0);
        run(1);
        chk("R3", "pend at 4096 after reset", 32'(pend), 32'd1);

        done = 1'b1;
        summary();
    end
endmodule